// File: doc/BRIEF.md
# Shared-Multiplier Small Vector Unit

This block is a custom-instruction execution unit that sits beside a scalar integer pipeline. It has its own private file of four short vector registers, three signed 32-bit elements each, and it executes four operations on them. A dot product reduces two vector registers to one scalar. An element-wise multiply writes a three-element vector back into the private file. Two transfer operations either place a general-purpose value into one vector element or return one vector element as a scalar. Scalar results go back to the core's integer register file through a result port.

A compile-time initiation interval `II` (1, 2 or 3) sets how many multipliers exist: ceil(3/II), so three, two or one. The same pool serves both the dot product and the element-wise multiply. Each accepted instruction is sliced into `II` phases, and each phase uses every multiplier of the pool once. Instructions enter through a valid/ready issue port. A transfer completes on the rising edge where `iss_valid` and `iss_ready` are both high. The core may hold `iss_valid` high while `iss_ready` is low. Nothing is taken on those edges, and the fields may change before the handshake. The result port has no ready signal. Its pulse lasts one cycle and the core must take it.

Top module: `svec_unit`

## Requirements
- R1: After reset, all twelve vector elements read as zero.
- R2: An instruction is taken only on a rising edge with `iss_valid` and `iss_ready` both high. An issue attempt while `iss_ready` is low changes no vector state and produces no result.
- R3: With II=1, `iss_ready` stays high, so an instruction can be taken every cycle. With II=2 or 3, `iss_ready` is low for exactly II-1 cycles after each accepted instruction.
- R4: A scalar instruction (dot product or element read) produces a one-cycle `res_valid` pulse exactly II+1 clock edges after its accepting edge, with `res_rd` equal to the `iss_rd` it was issued with. Vector-writing instructions never pulse `res_valid`.
- R5: Opcode 0 (dot product) returns va[0]*vb[0] + va[1]*vb[1] + va[2]*vb[2]. Each product keeps its low 32 bits, and the sum wraps modulo 2^32.
- R6: Opcode 1 (element-wise multiply) sets element i of vd to the low 32 bits of va[i]*vb[i], for i = 0..2.
- R7: Opcode 2 (element write) stores `iss_gpr` into element `iss_elem` of vd. An element index of 3 writes nothing.
- R8: Opcode 3 (element read) returns element `iss_elem` of va on `res_data`. An element index of 3 returns zero.
- R9: A vector write becomes visible to every instruction accepted after it, including one accepted on the first edge at which `iss_ready` allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | Unit can take an instruction on this edge |
| iss_op | input | 2 | Opcode: 0 dot, 1 multiply, 2 element write, 3 element read |
| iss_va | input | 2 | First source vector register |
| iss_vb | input | 2 | Second source vector register |
| iss_vd | input | 2 | Destination vector register |
| iss_elem | input | 2 | Element index for the transfer operations (0..2 valid) |
| iss_rd | input | 5 | Scalar destination index, returned with the result |
| iss_gpr | input | 32 | Scalar source value for an element write |
| res_valid | output | 1 | One-cycle scalar result pulse |
| res_rd | output | 5 | Scalar destination index of the result |
| res_data | output | 32 | Scalar result value |

## Verification
The checker assumes that `iss_valid` and `iss_op` are known in every cycle after reset. It takes `iss_rd` as known whenever an instruction is taken, and it assumes that the result consumer never needs to stall. The bench drives every issue field to a defined value at all times, including while idle, and samples the result port without ever holding it back. Random stimulus uses all four opcodes and all four element indices, including the out-of-range index 3. Directed cases add dependent back-to-back instructions and an issue attempt during a low-ready cycle.

// File: rtl/svec_pkg.sv
package svec_pkg;
  typedef enum logic [1:0] {
    OP_DOT  = 2'd0,
    OP_EMUL = 2'd1,
    OP_PUT  = 2'd2,
    OP_GET  = 2'd3
  } svec_op_e;
endpackage

// File: rtl/svec_issue_ctl.sv
module svec_issue_ctl #(
  parameter int II = 1,
  localparam int PH_W = (II > 1) ? $clog2(II) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            ready,
  output logic            accept,
  output logic            busy,
  output logic [PH_W-1:0] phase,
  output logic            last
);
  assign last   = busy && (phase == PH_W'(II - 1));
  assign ready  = !busy || last;
  assign accept = in_valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      phase <= '0;
    end else if (last) begin
      busy  <= 1'b0;
    end else if (busy) begin
      phase <= phase + 1'b1;
    end
  end
endmodule

// File: rtl/svec_regfile.sv
module svec_regfile #(
  parameter int W     = 32,
  parameter int NVREG = 4,
  parameter int NELEM = 3,
  localparam int VW = $clog2(NVREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NELEM-1:0]   wr_mask,
  input  logic [VW-1:0]      wr_sel,
  input  logic [NELEM*W-1:0] wr_data,
  input  logic [VW-1:0]      rd_a_sel,
  input  logic [VW-1:0]      rd_b_sel,
  output logic [NELEM*W-1:0] rd_a,
  output logic [NELEM*W-1:0] rd_b
);
  logic [W-1:0] mem [NVREG][NELEM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NVREG; r++)
        for (int e = 0; e < NELEM; e++)
          mem[r][e] <= '0;
    end else begin
      for (int e = 0; e < NELEM; e++)
        if (wr_mask[e]) mem[wr_sel][e] <= wr_data[e*W +: W];
    end
  end

  // Reads forward a write that lands on the coming edge.
  for (genvar e = 0; e < NELEM; e++) begin : g_rd
    assign rd_a[e*W +: W] = (wr_mask[e] && wr_sel == rd_a_sel) ? wr_data[e*W +: W] : mem[rd_a_sel][e];
    assign rd_b[e*W +: W] = (wr_mask[e] && wr_sel == rd_b_sel) ? wr_data[e*W +: W] : mem[rd_b_sel][e];
  end
endmodule

// File: rtl/svec_mul_pool.sv
module svec_mul_pool #(
  parameter int W     = 32,
  parameter int NELEM = 3,
  parameter int II    = 1,
  localparam int NMUL = (NELEM + II - 1) / II,
  localparam int PH_W = (II > 1) ? $clog2(II) : 1
) (
  input  logic [NELEM*W-1:0] a,
  input  logic [NELEM*W-1:0] b,
  input  logic [PH_W-1:0]    phase,
  output logic [NMUL*W-1:0]  prod
);
  for (genvar k = 0; k < NMUL; k++) begin : g_mul
    logic [W-1:0] opa, opb;
    always_comb begin
      opa = '0;
      opb = '0;
      if (int'(phase) * NMUL + k < NELEM) begin
        opa = a[(int'(phase) * NMUL + k) * W +: W];
        opb = b[(int'(phase) * NMUL + k) * W +: W];
      end
    end
    assign prod[k*W +: W] = opa * opb;
  end
endmodule

// File: rtl/svec_unit.sv
module svec_unit
  import svec_pkg::*;
#(
  parameter int W     = 32,
  parameter int NVREG = 4,
  parameter int NELEM = 3,
  parameter int RD_W  = 5,
  parameter int II    = 1,
  localparam int VW   = $clog2(NVREG),
  localparam int EW   = (NELEM > 1) ? $clog2(NELEM) : 1,
  localparam int NMUL = (NELEM + II - 1) / II,
  localparam int PH_W = (II > 1) ? $clog2(II) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [1:0]      iss_op,
  input  logic [VW-1:0]   iss_va,
  input  logic [VW-1:0]   iss_vb,
  input  logic [VW-1:0]   iss_vd,
  input  logic [EW-1:0]   iss_elem,
  input  logic [RD_W-1:0] iss_rd,
  input  logic [W-1:0]    iss_gpr,
  output logic            res_valid,
  output logic [RD_W-1:0] res_rd,
  output logic [W-1:0]    res_data
);
  logic            accept, busy, last;
  logic [PH_W-1:0] phase;

  svec_issue_ctl #(.II(II)) ctl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(iss_valid), .ready(iss_ready),
    .accept(accept), .busy(busy), .phase(phase), .last(last)
  );

  // Job register: held for the II phases of one instruction.
  svec_op_e        j_op;
  logic [VW-1:0]   j_va, j_vb, j_vd;
  logic [EW-1:0]   j_elem;
  logic [RD_W-1:0] j_rd;
  logic [W-1:0]    j_gpr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_op <= OP_DOT; j_va <= '0; j_vb <= '0; j_vd <= '0;
      j_elem <= '0; j_rd <= '0; j_gpr <= '0;
    end else if (accept) begin
      j_op <= svec_op_e'(iss_op); j_va <= iss_va; j_vb <= iss_vb; j_vd <= iss_vd;
      j_elem <= iss_elem; j_rd <= iss_rd; j_gpr <= iss_gpr;
    end
  end

  // Register file with a single write port driven by the finish stage.
  logic [NELEM-1:0]   wr_mask;
  logic [NELEM*W-1:0] wr_data, rd_a, rd_b;
  logic [VW-1:0]      wr_sel;

  svec_regfile #(.W(W), .NVREG(NVREG), .NELEM(NELEM)) rf_i (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_a_sel(j_va), .rd_b_sel(j_vb), .rd_a(rd_a), .rd_b(rd_b)
  );

  logic [NMUL*W-1:0] pool;

  svec_mul_pool #(.W(W), .NELEM(NELEM), .II(II)) mul_i (
    .a(rd_a), .b(rd_b), .phase(phase), .prod(pool)
  );

  // Product registers, filled slice by slice as phases advance.
  logic [NELEM*W-1:0] prod, prod_nx;

  always_comb begin
    prod_nx = prod;
    if (busy) begin
      for (int k = 0; k < NMUL; k++)
        if (int'(phase) * NMUL + k < NELEM)
          prod_nx[(int'(phase) * NMUL + k) * W +: W] = pool[k*W +: W];
    end
  end

  logic [W-1:0] gval;
  always_comb begin
    gval = '0;
    if (int'(j_elem) < NELEM) gval = rd_a[int'(j_elem) * W +: W];
  end

  // Finish stage: loaded on the edge that closes the last phase.
  logic            f_valid;
  svec_op_e        f_op;
  logic [VW-1:0]   f_vd;
  logic [EW-1:0]   f_elem;
  logic [RD_W-1:0] f_rd;
  logic [W-1:0]    f_gpr, f_gval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0; f_valid <= 1'b0; f_op <= OP_DOT; f_vd <= '0;
      f_elem <= '0; f_rd <= '0; f_gpr <= '0; f_gval <= '0;
    end else begin
      prod    <= prod_nx;
      f_valid <= last;
      if (last) begin
        f_op <= j_op; f_vd <= j_vd; f_elem <= j_elem;
        f_rd <= j_rd; f_gpr <= j_gpr; f_gval <= gval;
      end
    end
  end

  always_comb begin
    wr_sel  = f_vd;
    wr_mask = '0;
    wr_data = prod;
    if (f_valid && f_op == OP_EMUL) begin
      wr_mask = '1;
    end else if (f_valid && f_op == OP_PUT) begin
      wr_data = {NELEM{f_gpr}};
      for (int e = 0; e < NELEM; e++)
        if (int'(f_elem) == e) wr_mask[e] = 1'b1;
    end
  end

  logic [W-1:0] dot_sum;
  always_comb begin
    dot_sum = '0;
    for (int e = 0; e < NELEM; e++) dot_sum = dot_sum + prod[e*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0; res_rd <= '0; res_data <= '0;
    end else begin
      res_valid <= f_valid && (f_op == OP_DOT || f_op == OP_GET);
      res_rd    <= f_rd;
      res_data  <= (f_op == OP_DOT) ? dot_sum : f_gval;
    end
  end
endmodule

// File: rtl/svec_chk.sv
module svec_chk #(
  parameter int II   = 1,
  parameter int RD_W = 5,
  parameter int W    = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [1:0]      iss_op,
  input logic [RD_W-1:0] iss_rd,
  input logic            res_valid,
  input logic [RD_W-1:0] res_rd,
  input logic [W-1:0]    res_data
);
  localparam int D = II + 2;

  logic [D-1:0]    sc_sr;
  logic [RD_W-1:0] rd_sr [D];
  logic [3:0]      lowrun;
  logic            took_scalar;

  assign took_scalar = iss_valid && iss_ready && (iss_op == 2'd0 || iss_op == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_sr  <= '0;
      lowrun <= '0;
      for (int i = 0; i < D; i++) rd_sr[i] <= '0;
    end else begin
      sc_sr    <= {sc_sr[D-2:0], took_scalar};
      rd_sr[0] <= iss_rd;
      for (int i = 1; i < D; i++) rd_sr[i] <= rd_sr[i-1];
      lowrun   <= iss_ready ? 4'd0 : lowrun + 4'd1;
    end
  end

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) res_valid == sc_sr[D-1]); // R4
  AST_RES_RD: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> res_rd == rd_sr[D-1]); // R4
  AST_RES_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> !$isunknown(res_data)); // R5

  if (II > 1) begin : g_gap
    AST_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n) (iss_valid && iss_ready) |=> !iss_ready); // R3
    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) !iss_ready |-> lowrun < 4'(II - 1)); // R3
  end else begin : g_full
    AST_READY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n) iss_ready); // R3
  end
endmodule

bind svec_unit svec_chk #(.II(II), .RD_W(RD_W), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_op(iss_op), .iss_rd(iss_rd), .res_valid(res_valid), .res_rd(res_rd),
  .res_data(res_data)
);

// File: tb/svec_unit_tb.sv
module svec_unit_tb_top;
  localparam int TB_II = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic        iss_ready;
  logic [1:0]  iss_op = '0, iss_va = '0, iss_vb = '0, iss_vd = '0, iss_elem = '0;
  logic [4:0]  iss_rd = '0;
  logic [31:0] iss_gpr = '0;
  logic        res_valid;
  logic [4:0]  res_rd;
  logic [31:0] res_data;

  always #5 clk = ~clk;

  svec_unit #(.II(TB_II)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_va(iss_va), .iss_vb(iss_vb), .iss_vd(iss_vd),
    .iss_elem(iss_elem), .iss_rd(iss_rd), .iss_gpr(iss_gpr),
    .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [31:0] m [4][3];

  int          q_due [$];
  logic [4:0]  q_rd  [$];
  logic [31:0] q_val [$];
  string       q_tag [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_dot(input int a, input int b);
    logic [31:0] s = '0;
    for (int e = 0; e < 3; e++) s = s + m[a][e] * m[b][e];
    return s;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Result monitor, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(res_valid === 1'b1 && res_rd === q_rd[0], q_tag[0], "result pulse/rd",
            {58'd0, res_valid, res_rd}, {58'd0, 1'b1, q_rd[0]});
        chk(res_data === q_val[0], q_tag[0], "result data", {32'd0, res_data}, {32'd0, q_val[0]});
        void'(q_due.pop_front()); void'(q_rd.pop_front());
        void'(q_val.pop_front()); void'(q_tag.pop_front());
      end else begin
        chk(res_valid === 1'b0, "R4", "no pulse expected", {63'd0, res_valid}, 64'd0);
      end
    end
  end

  // Entered and left at a falling edge.
  task automatic issue(input logic [1:0] op, input logic [1:0] va, input logic [1:0] vb,
                       input logic [1:0] vd, input logic [1:0] el, input logic [4:0] rd,
                       input logic [31:0] gpr, input string tag);
    logic [31:0] v;
    while (!iss_ready) @(negedge clk);
    iss_valid = 1'b1; iss_op = op; iss_va = va; iss_vb = vb; iss_vd = vd;
    iss_elem = el; iss_rd = rd; iss_gpr = gpr;
    case (op)
      2'd0: begin
        q_due.push_back(cyc + 1 + TB_II + 1); q_rd.push_back(rd);
        q_val.push_back(f_dot(int'(va), int'(vb))); q_tag.push_back(tag);
      end
      2'd1: for (int e = 0; e < 3; e++) m[vd][e] = m[va][e] * m[vb][e];
      2'd2: if (el < 2'd3) m[vd][el] = gpr;
      default: begin
        v = (el < 2'd3) ? m[va][el] : 32'd0;
        q_due.push_back(cyc + 1 + TB_II + 1); q_rd.push_back(rd);
        q_val.push_back(v); q_tag.push_back(tag);
      end
    endcase
    @(negedge clk);
    iss_valid = 1'b0;
    chk(iss_ready === (TB_II == 1), "R3", "ready after accept",
        {63'd0, iss_ready}, {63'd0, TB_II == 1});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7321));
    for (int r = 0; r < 4; r++) for (int e = 0; e < 3; e++) m[r][e] = '0;
    repeat (3) @(negedge clk);
    chk(iss_ready === 1'b1, "R2", "ready in reset", {63'd0, iss_ready}, 64'd1);
    chk(res_valid === 1'b0, "R4", "no result in reset", {63'd0, res_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: every element starts at zero.
    for (int r = 0; r < 4; r++)
      for (int e = 0; e < 3; e++)
        issue(2'd3, 2'(r), 2'd0, 2'd0, 2'(e), 5'(r * 3 + e), 32'd0, "R1");
    issue(2'd3, 2'd1, 2'd0, 2'd0, 2'd3, 5'd30, 32'd0, "R8");

    // R7: element writes, with an out-of-range index that is dropped.
    issue(2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 5'd0, 32'h8000_0000, "R7");
    issue(2'd2, 2'd0, 2'd0, 2'd0, 2'd1, 5'd0, 32'hFFFF_FFFF, "R7");
    issue(2'd2, 2'd0, 2'd0, 2'd0, 2'd2, 5'd0, 32'h7FFF_FFFF, "R7");
    issue(2'd2, 2'd0, 2'd0, 2'd0, 2'd3, 5'd0, 32'h1234_5678, "R7");
    for (int e = 0; e < 3; e++) issue(2'd3, 2'd0, 2'd0, 2'd0, 2'(e), 5'd7, 32'd0, "R7");

    // R9: dependent read right behind the write.
    issue(2'd2, 2'd0, 2'd0, 2'd1, 2'd0, 5'd0, 32'hFFFF_FFFE, "R9");
    issue(2'd3, 2'd1, 2'd0, 2'd0, 2'd0, 5'd9, 32'd0, "R9");
    issue(2'd2, 2'd0, 2'd0, 2'd1, 2'd1, 5'd0, 32'h0000_0003, "R9");
    issue(2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 5'd0, 32'h8000_0001, "R9");

    // R5: dot product with wrapping products and sum.
    issue(2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 5'd11, 32'd0, "R5");
    issue(2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 5'd12, 32'd0, "R5");

    // R6 and R9: multiply then consume its destination at once.
    issue(2'd1, 2'd0, 2'd1, 2'd2, 2'd0, 5'd0, 32'd0, "R6");
    issue(2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 5'd13, 32'd0, "R9");
    for (int e = 0; e < 3; e++) issue(2'd3, 2'd2, 2'd0, 2'd0, 2'(e), 5'd14, 32'd0, "R6");

    // R2: attempt during a low-ready cycle is dropped.
    issue(2'd3, 2'd3, 2'd0, 2'd0, 2'd0, 5'd15, 32'd0, "R8");
    chk(iss_ready === 1'b0, "R2", "ready low before attempt", {63'd0, iss_ready}, 64'd0);
    iss_valid = 1'b1; iss_op = 2'd2; iss_vd = 2'd3; iss_elem = 2'd0; iss_gpr = 32'hDEAD_BEEF;
    @(negedge clk);
    iss_valid = 1'b0;
    issue(2'd3, 2'd3, 2'd0, 2'd0, 2'd0, 5'd16, 32'd0, "R2");

    // Random mix of all operations.
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      issue(op, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            2'($urandom_range(0, 3)), 5'($urandom_range(0, 31)), $urandom(),
            (op == 2'd0) ? "R5" : "R8");
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    repeat (TB_II + 6) @(negedge clk);
    chk(q_due.size() == 0, "R4", "all results delivered", 64'(q_due.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule